// File: doc/BRIEF.md
# Graphics Aperture Address Translator

This block maps addresses that fall inside a graphics aperture onto physical memory pages. The mapping comes from a page table that lives in system memory and holds one 32-bit entry per 4 KB page. A small fully associative cache of recent translations sits in front of the table walk. On a miss, the block fetches exactly one table entry through a memory read port. It swaps the bytes of that little-endian word, checks the entry's valid flag, and either answers with the physical address or reports an error.

Software sets the block up through a small register port with four registers:

- the aperture base;
- the table base and its size;
- a control word;
- a read-only status word.

Control writes can empty the translation cache, pulse a soft reset into the walker, and enable or disable translation. The intended use is:

- **Invalidation.** Write enable with invalidate, then enable alone, then enable with reset, then enable alone.
- **Shutdown.** Poll the status word until the block is idle. Then write invalidate with enable, zero, reset alone, and zero.

Top module: `aperture_xlate`

## Requirements
- R1: Register select 0 is the aperture base. Only its top 4 bits are stored, and the lower 28 bits read back as zero. The aperture offset of a request is the request address minus this base, and the page index is that offset shifted right by 12.
- R2: Register select 1 is the table register. Bits 31:12 hold the page-aligned table address and bits 11:0 hold the table size in 4 KB table pages, so the table has size × 1024 entries. A page index at or above that limit is answered with an error one cycle after acceptance, and no memory read is issued.
- R3: On a cache miss, the block issues one memory read at the table address plus 4 × index. It byte-swaps the returned word, uses bit 0 as the valid flag, and returns the physical address formed from bits 31:12 of the swapped word and bits 11:0 of the request.
- R4: An entry whose valid bit is 0 produces an error response and is not cached, so a repeated request fetches the entry again.
- R5: A valid fetched entry is cached. A later request to the same page is answered one cycle after acceptance with no memory read.
- R6: Fills replace cache slots in round-robin order across the 4 slots. After 5 distinct fills from an empty cache with the pointer at slot 0, the first page misses and the second still hits.
- R7: Register select 2 is control: bit 8 enables translation, and bit 17 is a stored flag with no other effect. Bits 0 (invalidate) and 16 (soft reset) act only as write strobes and read back as 0. Any control write with bit 0 set empties the cache.
- R8: After the four-write invalidate sequence, a page that was cached before the sequence misses and is fetched again.
- R9: While enable is 0, a request is answered one cycle after acceptance with an error, no memory read occurs, and the cache is held empty.
- R10: Register select 3 is status: bit 0 reads 1 while a table fetch is outstanding and 0 when the walker is idle.
- R11: An invalidate that arrives while a fetch is outstanding does not stop the response. It does stop that fetched entry from being cached.
- R12: The soft-reset strobe returns the walker to idle at once and ignores read data that arrives afterwards. It resets the round-robin pointer to slot 0 and leaves the aperture and table registers unchanged.
- R13: After the shutdown write sequence, control reads back 0 and every request is answered with an error and no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 aperture, 1 table, 2 control, 3 status) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| req_valid | input | 1 | Translation request valid |
| req_addr | input | 32 | Aperture address to translate |
| req_ready | output | 1 | Walker idle and able to accept a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is an error |
| rsp_addr | output | 32 | Translated physical address |
| mem_rd_valid | output | 1 | Table-entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rdata_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table entry as stored in memory (little-endian) |

## Verification
A stale cache slot shows up as a physical address on a one-cycle response with no memory read where a fetch was due. The bench can therefore see it on the very next request to that page. A wrong round-robin pointer or a missed flush becomes visible as a hit or a miss on the wrong page a few requests later, and the fetch count and fetch address make this observable. A walker stuck outside idle shows as status bit 0 stuck at 1 and req_ready held low. A walker that fails to ignore late read data shows as a response pulse that no request asked for.

// File: rtl/axl_pkg.sv
package axl_pkg;
   typedef enum logic [1:0] {
      SEL_APER  = 2'd0,
      SEL_TABLE = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_STAT  = 2'd3
   } cfg_sel_e;

   typedef enum logic [1:0] {
      W_IDLE  = 2'd0,
      W_FETCH = 2'd1,
      W_WAIT  = 2'd2
   } walk_st_e;

   localparam int CTL_INVAL_BIT = 0;
   localparam int CTL_EN_BIT    = 8;
   localparam int CTL_RST_BIT   = 16;
   localparam int CTL_DIS_BIT   = 17;
endpackage

// File: rtl/axl_cfg_regs.sv
module axl_cfg_regs
   import axl_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int AP_KEEP    = 4,
   parameter int PAGE_SHIFT = 12
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_wr,
   input  logic [1:0]                   cfg_sel,
   input  logic [ADDR_W-1:0]            cfg_wdata,
   output logic [ADDR_W-1:0]            cfg_rdata,
   input  logic                         busy,
   output logic [AP_KEEP-1:0]           ap_hi,
   output logic [ADDR_W-PAGE_SHIFT-1:0] tbl_pg,
   output logic [PAGE_SHIFT-1:0]        tbl_pages,
   output logic                         enable,
   output logic                         inval_stb,
   output logic                         rst_stb
);
   localparam int PG_W = ADDR_W - PAGE_SHIFT;

   if (ADDR_W <= CTL_DIS_BIT) begin : g_chk_width
      $error("axl_cfg_regs: ADDR_W too small for the control word");
   end
   if (AP_KEEP < 1 || AP_KEEP >= ADDR_W) begin : g_chk_keep
      $error("axl_cfg_regs: AP_KEEP out of range");
   end

   logic wr_ctrl;
   logic dis_q;
   logic [ADDR_W-1:0] ctl_rd;

   assign wr_ctrl   = cfg_wr && (cfg_sel == SEL_CTRL);
   assign inval_stb = wr_ctrl && cfg_wdata[CTL_INVAL_BIT];
   assign rst_stb   = wr_ctrl && cfg_wdata[CTL_RST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ap_hi     <= '0;
         tbl_pg    <= '0;
         tbl_pages <= '0;
         enable    <= 1'b0;
         dis_q     <= 1'b0;
      end else if (cfg_wr) begin
         case (cfg_sel)
            SEL_APER:  ap_hi <= cfg_wdata[ADDR_W-1 -: AP_KEEP];
            SEL_TABLE: begin
               tbl_pg    <= cfg_wdata[ADDR_W-1 -: PG_W];
               tbl_pages <= cfg_wdata[PAGE_SHIFT-1:0];
            end
            SEL_CTRL: begin
               enable <= cfg_wdata[CTL_EN_BIT];
               dis_q  <= cfg_wdata[CTL_DIS_BIT];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      ctl_rd              = '0;
      ctl_rd[CTL_EN_BIT]  = enable;
      ctl_rd[CTL_DIS_BIT] = dis_q;
   end

   always_comb begin
      case (cfg_sel)
         SEL_APER:  cfg_rdata = {ap_hi, {(ADDR_W-AP_KEEP){1'b0}}};
         SEL_TABLE: cfg_rdata = {tbl_pg, tbl_pages};
         SEL_CTRL:  cfg_rdata = ctl_rd;
         default:   cfg_rdata = {{(ADDR_W-1){1'b0}}, busy};
      endcase
   end
endmodule

// File: rtl/axl_tlb.sv
module axl_tlb #(
   parameter int DEPTH = 4,
   parameter int TAG_W = 20,
   parameter int FRM_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             rr_clr,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   output logic [FRM_W-1:0] lk_frm,
   input  logic             fill,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic [FRM_W-1:0] fill_frm
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || DEPTH > 64) begin : g_chk_depth
      $error("axl_tlb: DEPTH must lie in 2..64");
   end

   logic [PTR_W-1:0]            rr_q;
   logic [DEPTH-1:0]            hit_vec;
   logic [DEPTH-1:0][FRM_W-1:0] frm_m;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic             v_q;
      logic [TAG_W-1:0] tag_q;
      logic [FRM_W-1:0] frm_q;
      logic             take;

      assign take = fill && !flush && (rr_q == PTR_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      v_q <= 1'b0;
         else if (flush)  v_q <= 1'b0;
         else if (take)   v_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (take) begin
            tag_q <= fill_tag;
            frm_q <= fill_frm;
         end
      end

      assign hit_vec[i] = v_q && (tag_q == lk_tag);
      assign frm_m[i]   = hit_vec[i] ? frm_q : '0;
   end

   always_comb begin
      lk_frm = '0;
      for (int i = 0; i < DEPTH; i++) lk_frm = lk_frm | frm_m[i];
   end
   assign lk_hit = |hit_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rr_q <= '0;
      else if (rr_clr)           rr_q <= '0;
      else if (fill && !flush)   rr_q <= (rr_q == PTR_W'(DEPTH-1)) ? '0 : rr_q + 1'b1;
   end

   p_unique_hit_r6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec))
      else $error("R6: more than one slot holds the same page");
endmodule

// File: rtl/axl_walker.sv
module axl_walker
   import axl_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int AP_KEEP    = 4,
   parameter int PAGE_SHIFT = 12
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         soft_rst,
   input  logic                         flush,
   input  logic                         enable,
   input  logic [AP_KEEP-1:0]           ap_hi,
   input  logic [ADDR_W-PAGE_SHIFT-1:0] tbl_pg,
   input  logic [PAGE_SHIFT-1:0]        tbl_pages,
   input  logic                         req_valid,
   input  logic [ADDR_W-1:0]            req_addr,
   output logic                         req_ready,
   output logic                         rsp_valid,
   output logic                         rsp_err,
   output logic [ADDR_W-1:0]            rsp_addr,
   output logic [ADDR_W-PAGE_SHIFT-1:0] lk_tag,
   input  logic                         lk_hit,
   input  logic [ADDR_W-PAGE_SHIFT-1:0] lk_frm,
   output logic                         fill_en,
   output logic [ADDR_W-PAGE_SHIFT-1:0] fill_tag,
   output logic [ADDR_W-PAGE_SHIFT-1:0] fill_frm,
   output logic                         mem_rd_valid,
   input  logic                         mem_rd_ready,
   output logic [ADDR_W-1:0]            mem_rd_addr,
   input  logic                         mem_rdata_valid,
   input  logic [ADDR_W-1:0]            mem_rdata,
   output logic                         busy
);
   localparam int IDX_W  = ADDR_W - PAGE_SHIFT;
   localparam int NBYTES = ADDR_W / 8;
   localparam int ESZ_SH = $clog2(NBYTES);
   localparam int EPP_SH = PAGE_SHIFT - ESZ_SH;

   if (ADDR_W % 8 != 0) begin : g_chk_bytes
      $error("axl_walker: ADDR_W must be whole bytes");
   end
   if (PAGE_SHIFT + EPP_SH > ADDR_W) begin : g_chk_limit
      $error("axl_walker: table size limit does not fit ADDR_W");
   end

   walk_st_e          st_q;
   logic              stale_q;
   logic [IDX_W-1:0]  fidx_q;
   logic [PAGE_SHIFT-1:0] foff_q;
   logic [ADDR_W-1:0] faddr_q;

   logic [ADDR_W-1:0] off;
   logic [IDX_W-1:0]  idx;
   logic              oob;
   logic              accept;
   logic [ADDR_W-1:0] swapped;
   logic              ent_ok;
   logic [IDX_W-1:0]  ent_frm;
   logic [ADDR_W-1:0] lim;

   assign off = req_addr - {ap_hi, {(ADDR_W-AP_KEEP){1'b0}}};
   assign idx = off[ADDR_W-1:PAGE_SHIFT];
   assign lim = ADDR_W'(tbl_pages) << EPP_SH;
   assign oob = ADDR_W'(idx) >= lim;
   assign lk_tag = idx;

   for (genvar b = 0; b < NBYTES; b++) begin : g_swap
      assign swapped[8*b +: 8] = mem_rdata[8*(NBYTES-1-b) +: 8];
   end
   assign ent_ok  = swapped[0];
   assign ent_frm = swapped[ADDR_W-1:PAGE_SHIFT];

   logic unused_walk;
   assign unused_walk = ^{swapped[PAGE_SHIFT-1:1], off[PAGE_SHIFT-1:0]};

   assign req_ready    = (st_q == W_IDLE);
   assign accept       = req_valid && req_ready && !soft_rst;
   assign busy         = (st_q != W_IDLE);
   assign mem_rd_valid = (st_q == W_FETCH);
   assign mem_rd_addr  = faddr_q;

   assign fill_en  = (st_q == W_WAIT) && mem_rdata_valid && ent_ok && !stale_q && !flush && !soft_rst;
   assign fill_tag = fidx_q;
   assign fill_frm = ent_frm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= W_IDLE;
         stale_q   <= 1'b0;
         fidx_q    <= '0;
         foff_q    <= '0;
         faddr_q   <= '0;
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_addr  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (flush && st_q != W_IDLE) stale_q <= 1'b1;
         if (soft_rst) begin
            st_q <= W_IDLE;
         end else begin
            case (st_q)
               W_IDLE: if (req_valid) begin
                  if (!enable || oob) begin
                     rsp_valid <= 1'b1;
                     rsp_err   <= 1'b1;
                     rsp_addr  <= '0;
                  end else if (lk_hit) begin
                     rsp_valid <= 1'b1;
                     rsp_err   <= 1'b0;
                     rsp_addr  <= {lk_frm, req_addr[PAGE_SHIFT-1:0]};
                  end else begin
                     st_q    <= W_FETCH;
                     stale_q <= 1'b0;
                     fidx_q  <= idx;
                     foff_q  <= req_addr[PAGE_SHIFT-1:0];
                     faddr_q <= {tbl_pg, {PAGE_SHIFT{1'b0}}} + (ADDR_W'(idx) << ESZ_SH);
                  end
               end
               W_FETCH: if (mem_rd_ready) st_q <= W_WAIT;
               W_WAIT: if (mem_rdata_valid) begin
                  st_q      <= W_IDLE;
                  rsp_valid <= 1'b1;
                  rsp_err   <= !ent_ok;
                  rsp_addr  <= ent_ok ? {ent_frm, foff_q} : '0;
               end
               default: st_q <= W_IDLE;
            endcase
         end
      end
   end

   p_off_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !enable |=> rsp_valid && rsp_err && !mem_rd_valid)
      else $error("R9: disabled request not refused at once");

   p_range_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept && enable && oob |=> rsp_valid && rsp_err && !mem_rd_valid)
      else $error("R2: out-of-range index not refused at once");

   p_hold_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid && !mem_rd_ready && !soft_rst |=> mem_rd_valid && $stable(mem_rd_addr))
      else $error("R3: table read dropped or changed before acceptance");

   p_busy_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
      accept && enable && !oob && !lk_hit |=> busy && !rsp_valid)
      else $error("R10: miss did not leave the walker busy");
endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate #(
   parameter int ADDR_W     = 32,
   parameter int AP_KEEP    = 4,
   parameter int PAGE_SHIFT = 12,
   parameter int TLB_DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] cfg_rdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rdata_valid,
   input  logic [ADDR_W-1:0] mem_rdata
);
   localparam int IDX_W = ADDR_W - PAGE_SHIFT;

   logic [AP_KEEP-1:0]    ap_hi;
   logic [IDX_W-1:0]      tbl_pg;
   logic [PAGE_SHIFT-1:0] tbl_pages;
   logic                  enable, inval_stb, rst_stb, busy, flush;
   logic [IDX_W-1:0]      lk_tag, lk_frm, fill_tag, fill_frm;
   logic                  lk_hit, fill_en;

   assign flush = inval_stb || !enable;

   axl_cfg_regs #(.ADDR_W(ADDR_W), .AP_KEEP(AP_KEEP), .PAGE_SHIFT(PAGE_SHIFT)) u_cfg (
      .clk, .rst_n, .cfg_wr, .cfg_sel, .cfg_wdata, .cfg_rdata, .busy,
      .ap_hi, .tbl_pg, .tbl_pages, .enable, .inval_stb, .rst_stb
   );

   axl_tlb #(.DEPTH(TLB_DEPTH), .TAG_W(IDX_W), .FRM_W(IDX_W)) u_tlb (
      .clk, .rst_n, .flush, .rr_clr(rst_stb), .lk_tag, .lk_hit, .lk_frm,
      .fill(fill_en), .fill_tag, .fill_frm
   );

   axl_walker #(.ADDR_W(ADDR_W), .AP_KEEP(AP_KEEP), .PAGE_SHIFT(PAGE_SHIFT)) u_walk (
      .clk, .rst_n, .soft_rst(rst_stb), .flush, .enable, .ap_hi, .tbl_pg, .tbl_pages,
      .req_valid, .req_addr, .req_ready, .rsp_valid, .rsp_err, .rsp_addr,
      .lk_tag, .lk_hit, .lk_frm, .fill_en, .fill_tag, .fill_frm,
      .mem_rd_valid, .mem_rd_ready, .mem_rd_addr, .mem_rdata_valid, .mem_rdata, .busy
   );
endmodule

// File: tb/aperture_xlate_tb_top.sv
`timescale 1ns/1ps
module aperture_xlate_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_ready, rsp_valid, rsp_err;
   logic [31:0] rsp_addr;
   logic        mem_rd_valid;
   logic        mem_rd_ready;
   logic [31:0] mem_rd_addr;
   logic        mem_rdata_valid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int checks = 0, fails = 0, reads = 0, rsps = 0, rd_cnt = 0;
   bit hold = 1'b0;
   logic [31:0] last_fa = '0, pend_fa = '0;
   bit          qe[$];
   logic [31:0] qa[$];
   string       qt[$];
   bit          m_e;
   logic [31:0] m_a;
   string       m_t;

   always #2 clk = ~clk;
   assign mem_rd_ready = 1'b1;

   aperture_xlate dut_i (
      .clk, .rst_n, .cfg_wr, .cfg_sel, .cfg_wdata, .cfg_rdata,
      .req_valid, .req_addr, .req_ready, .rsp_valid, .rsp_err, .rsp_addr,
      .mem_rd_valid, .mem_rd_ready, .mem_rd_addr, .mem_rdata_valid, .mem_rdata
   );

   function automatic logic [31:0] entry_of(input logic [31:0] fa);
      logic [31:0] l;
      l = {fa[21:2] + 20'h12345, 11'h000, (fa[4:2] != 3'd3)};
      return {l[7:0], l[15:8], l[23:16], l[31:24]};
   endfunction

   function automatic logic [31:0] fetch_of(input logic [31:0] a);
      return 32'h0010_0000 + (((a - 32'h8000_0000) >> 12) << 2);
   endfunction

   function automatic logic [31:0] ap(input int idx, input logic [11:0] o);
      return 32'h8000_0000 + (idx << 12) + {20'h0, o};
   endfunction

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // memory model: answers table reads three cycles later unless held
   always @(negedge clk) begin
      mem_rdata_valid = 1'b0;
      if (rd_cnt > 0) begin
         if (!(rd_cnt == 1 && hold)) rd_cnt--;
         if (rd_cnt == 0) begin
            mem_rdata_valid = 1'b1;
            mem_rdata = entry_of(pend_fa);
         end
      end
      if (rst_n && mem_rd_valid) begin
         pend_fa = mem_rd_addr;
         last_fa = mem_rd_addr;
         reads++;
         rd_cnt = 3;
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         rsps++;
         if (qe.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL R12 unexpected response actual=%h expected=none", rsp_addr);
         end else begin
            m_e = qe.pop_front();
            m_a = qa.pop_front();
            m_t = qt.pop_front();
            chk({m_t, " error flag"}, {31'b0, rsp_err}, {31'b0, m_e});
            if (!m_e) chk({m_t, " physical address"}, rsp_addr, m_a);
         end
      end
   end

   task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic cfg_read(input logic [1:0] s, output logic [31:0] d);
      cfg_sel = s;
      #0.5;
      d = cfg_rdata;
   endtask

   task automatic xlate(input logic [31:0] a, input bit e_err, input bit e_fetch,
                        input bit lat1, input string tag);
      int r0, n;
      logic [31:0] fa;
      fa = fetch_of(a);
      qe.push_back(e_err);
      qa.push_back({fa[21:2] + 20'h12345, a[11:0]});
      qt.push_back(tag);
      r0 = reads;
      @(negedge clk);
      n = 0;
      while (!req_ready && n < 1000) begin @(negedge clk); n++; end
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      if (lat1) chk({tag, " one-cycle response"}, {31'b0, rsp_valid}, 32'd1);
      n = 0;
      while (qe.size() != 0 && n < 1000) begin @(negedge clk); n++; end
      chk({tag, " response arrived"}, qe.size(), 32'd0);
      chk({tag, " table reads"}, reads - r0, {31'b0, e_fetch});
      if (e_fetch) chk({tag, " table read address"}, last_fa, fa);
   endtask

   initial begin
      #(4 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      int r0, s0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R10 reset req_ready", {31'b0, req_ready}, 32'd1);
      chk("R10 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
      chk("R10 reset mem_rd_valid", {31'b0, mem_rd_valid}, 32'd0);
      cfg_read(2'd3, d); chk("R10 reset status", d, 32'd0);
      cfg_read(2'd2, d); chk("R7 reset control", d, 32'd0);

      cfg_write(2'd0, 32'h8123_4567);
      cfg_read(2'd0, d); chk("R1 aperture readback", d, 32'h8000_0000);
      cfg_write(2'd1, 32'h0010_0002);
      cfg_read(2'd1, d); chk("R2 table readback", d, 32'h0010_0002);

      // disabled: immediate error, no fetch
      xlate(ap(0, 12'h010), 1'b1, 1'b0, 1'b1, "R9 disabled");

      cfg_write(2'd2, 32'h0003_0101);
      cfg_read(2'd2, d); chk("R7 control strobes read zero", d, 32'h0002_0100);
      // miss then hit, with the stored flag set
      xlate(ap(0, 12'h123), 1'b0, 1'b1, 1'b0, "R3 miss fetch");
      xlate(ap(0, 12'hFFF), 1'b0, 1'b0, 1'b1, "R5 hit");
      cfg_write(2'd2, 32'h0000_0100);
      cfg_read(2'd2, d); chk("R7 flag cleared", d, 32'h0000_0100);
      xlate(ap(0, 12'h004), 1'b0, 1'b0, 1'b1, "R7 flag no effect hit");
      // invalid entry
      xlate(ap(3, 12'h000), 1'b1, 1'b1, 1'b0, "R4 invalid entry");
      xlate(ap(3, 12'h008), 1'b1, 1'b1, 1'b0, "R4 invalid not cached");
      // range limit 2 table pages = 2048 entries
      xlate(ap(2047, 12'hABC), 1'b0, 1'b1, 1'b0, "R2 last index");
      xlate(ap(2048, 12'h000), 1'b1, 1'b0, 1'b1, "R2 beyond limit");
      xlate(32'h7FFF_F000, 1'b1, 1'b0, 1'b1, "R1 below aperture");

      // round robin from slot 0
      cfg_write(2'd2, 32'h0001_0101);
      xlate(ap(8, 12'h1), 1'b0, 1'b1, 1'b0, "R6 fill 8");
      xlate(ap(9, 12'h2), 1'b0, 1'b1, 1'b0, "R6 fill 9");
      xlate(ap(10, 12'h3), 1'b0, 1'b1, 1'b0, "R6 fill 10");
      xlate(ap(12, 12'h4), 1'b0, 1'b1, 1'b0, "R6 fill 12");
      xlate(ap(13, 12'h5), 1'b0, 1'b1, 1'b0, "R6 fill 13");
      xlate(ap(9, 12'h6), 1'b0, 1'b0, 1'b1, "R6 second page kept");
      xlate(ap(8, 12'h7), 1'b0, 1'b1, 1'b0, "R6 first page evicted");

      // invalidate sequence
      xlate(ap(10, 12'h8), 1'b0, 1'b0, 1'b1, "R8 cached before");
      cfg_write(2'd2, 32'h0000_0101);
      cfg_write(2'd2, 32'h0000_0100);
      cfg_write(2'd2, 32'h0001_0100);
      cfg_write(2'd2, 32'h0000_0100);
      xlate(ap(10, 12'h9), 1'b0, 1'b1, 1'b0, "R8 refetched");

      // flush during an outstanding fetch
      hold = 1'b1;
      r0 = reads;
      fork
         xlate(ap(16, 12'h0AA), 1'b0, 1'b1, 1'b0, "R11 response kept");
         begin
            while (reads == r0) @(negedge clk);
            cfg_read(2'd3, d); chk("R10 busy during fetch", d, 32'd1);
            cfg_write(2'd2, 32'h0000_0101);
            hold = 1'b0;
         end
      join
      xlate(ap(16, 12'h0BB), 1'b0, 1'b1, 1'b0, "R11 result not cached");

      // soft reset abandons a fetch
      hold = 1'b1;
      r0 = reads;
      @(negedge clk);
      req_valid = 1'b1; req_addr = ap(24, 12'h0);
      @(negedge clk);
      req_valid = 1'b0;
      while (reads == r0) @(negedge clk);
      cfg_read(2'd3, d); chk("R10 busy before soft reset", d, 32'd1);
      cfg_write(2'd2, 32'h0001_0100);
      cfg_read(2'd3, d); chk("R12 idle after soft reset", d, 32'd0);
      s0 = rsps;
      hold = 1'b0;
      repeat (10) @(negedge clk);
      chk("R12 late data ignored", rsps - s0, 32'd0);
      cfg_read(2'd0, d); chk("R12 aperture kept", d, 32'h8000_0000);
      cfg_read(2'd1, d); chk("R12 table kept", d, 32'h0010_0002);

      // soft reset clears the round-robin pointer
      cfg_write(2'd2, 32'h0001_0101);
      xlate(ap(32, 12'h1), 1'b0, 1'b1, 1'b0, "R12 fill A");
      xlate(ap(33, 12'h2), 1'b0, 1'b1, 1'b0, "R12 fill B");
      cfg_write(2'd2, 32'h0001_0100);
      xlate(ap(34, 12'h3), 1'b0, 1'b1, 1'b0, "R12 fill C");
      xlate(ap(33, 12'h4), 1'b0, 1'b0, 1'b1, "R12 B still cached");
      xlate(ap(32, 12'h5), 1'b0, 1'b1, 1'b0, "R12 A replaced by C");

      // shutdown
      cfg_read(2'd3, d); chk("R13 idle before shutdown", d, 32'd0);
      cfg_write(2'd2, 32'h0000_0101);
      cfg_write(2'd2, 32'h0000_0000);
      cfg_write(2'd2, 32'h0001_0000);
      cfg_write(2'd2, 32'h0000_0000);
      cfg_read(2'd2, d); chk("R13 control zero", d, 32'd0);
      xlate(ap(33, 12'h6), 1'b1, 1'b0, 1'b1, "R13 refused after shutdown");
      // re-enable: cache emptied while disabled
      cfg_write(2'd2, 32'h0000_0100);
      xlate(ap(33, 12'h7), 1'b0, 1'b1, 1'b0, "R9 cache empty after disable");

      repeat (5) @(negedge clk);
      summary();
      $finish;
   end
endmodule